// File: doc/BRIEF.md
# Monochrome OLED Refresh Sequencer

This block runs a 128x64 page-addressed monochrome OLED controller over a serial link that only writes. The link has three wires: a serial clock, serial data and a command/data select. The panel's chip select is tied active and never framed, so the controller's bit counter cannot be resynchronised. A single stray clock edge would shift the alignment of every byte that follows. The block therefore holds clock and select at their idle-high levels from reset. It counts exactly eight rising edges per byte and lets data move only while the clock is low.

After reset the block raises the panel power-enable. It waits a parameterised number of system cycles for the rail to settle and then sends a fixed 24-byte power-up command list. After that it idles. Each refresh request sends a full frame taken from a 1024-byte framebuffer, which the block reads through a synchronous port with one cycle of read latency. The frame goes out as eight pages, and each page is a three-command address header followed by 128 data bytes. A request that arrives while the block is busy is remembered and served once the current work ends.

Top module: `oled_refresh_seq`

## Requirements
- R1: While reset is asserted, and whenever `busy_o` is low, `sclk_o` and `dc_o` are both high. During reset `pwr_en_o` and `fb_rd_o` are low and `busy_o` is high.
- R2: `pwr_en_o` rises in the first cycle after reset is released and stays high from then on. No `sclk_o` edge occurs before it rises, and the first `sclk_o` edge comes at least `SETTLE_CYC` system cycles after it rises.
- R3: After the settling delay the block sends 24 command bytes in this order: AE D5 80 A8 3F D3 00 40 A1 C8 DA 12 81 FF 8D 14 D9 F1 DB 40 A4 A6 2E AF.
- R4: Each byte gives exactly 8 rising edges of `sclk_o`, most significant bit first, and is sampled on the rising edge. `sdin_o` changes only in cycles where `sclk_o` is low. Between bytes no partial byte is left in flight.
- R5: `dc_o` is low (0) for all 8 bits of a command byte and high (1) for all 8 bits of a data byte. It does not change on a rising clock edge, and it returns high when a command byte ends.
- R6: A frame is 8 pages, sent in the order page 0 to page 7. Page p starts with the commands 0xB0|p, then 0x00, then 0x10. It continues with the 128 data bytes at framebuffer addresses p*128+c, for c = 0..127 in ascending order.
- R7: The framebuffer is read with a one-cycle `fb_rd_o` strobe. The byte on `fb_data_i` in the following cycle is the one sent, and every address is below 1024.
- R8: `refresh_i` is latched at any time after reset, including during settling, initialisation or a frame. Any number of requests made while busy start exactly one frame once the current work completes.
- R9: `busy_o` stays high from reset until the power-up list is finished and for the whole of each frame, until its last data bit has been sent. It is low otherwise, and it goes high in the cycle after a request that arrives while idle.
- R10: When no request is pending, no serial activity follows the end of the power-up list or the end of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| refresh_i | input | 1 | One-cycle request to send a full frame |
| fb_rd_o | output | 1 | Framebuffer read strobe |
| fb_addr_o | output | 10 | Framebuffer byte address (page*128+column) |
| fb_data_i | input | 8 | Framebuffer read data, valid one cycle after the strobe |
| pwr_en_o | output | 1 | Panel power enable, active high |
| sclk_o | output | 1 | Serial clock, idle high |
| sdin_o | output | 1 | Serial data, MSB first |
| dc_o | output | 1 | Command (0) / data (1) select, idle high |
| busy_o | output | 1 | Initialisation or frame in progress |

## Verification
The bench decodes the serial line as a panel would, on rising clock edges with the select line captured per byte. It compares the whole stream against one built arithmetically: the power-up list, then three frames. Two framebuffer patterns with different address-to-value formulas are used, so a swapped page/column order, an off-by-one read latency or a reversed bit order each produce distinct mismatches. A request made during settling, and two more made inside a running frame, must each give exactly one extra frame. A request while idle checks how quickly `busy_o` rises, and quiet stretches check that no stray edge or partial byte appears.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;

  localparam int INIT_LEN = 24;
  localparam int HDR_LEN  = 3;

  localparam logic [7:0] CMD_PAGE   = 8'hB0;
  localparam logic [7:0] CMD_COL_LO = 8'h00;
  localparam logic [7:0] CMD_COL_HI = 8'h10;

  typedef enum logic [2:0] {
    ST_PWR, ST_SETTLE, ST_ISSUE, ST_LOAD, ST_WAIT, ST_IDLE
  } seq_state_e;

  function automatic logic [7:0] init_byte(input logic [4:0] i);
    case (i)
      5'd0:  return 8'hAE;
      5'd1:  return 8'hD5;
      5'd2:  return 8'h80;
      5'd3:  return 8'hA8;
      5'd4:  return 8'h3F;
      5'd5:  return 8'hD3;
      5'd6:  return 8'h00;
      5'd7:  return 8'h40;
      5'd8:  return 8'hA1;
      5'd9:  return 8'hC8;
      5'd10: return 8'hDA;
      5'd11: return 8'h12;
      5'd12: return 8'h81;
      5'd13: return 8'hFF;
      5'd14: return 8'h8D;
      5'd15: return 8'h14;
      5'd16: return 8'hD9;
      5'd17: return 8'hF1;
      5'd18: return 8'hDB;
      5'd19: return 8'h40;
      5'd20: return 8'hA4;
      5'd21: return 8'hA6;
      5'd22: return 8'h2E;
      default: return 8'hAF;
    endcase
  endfunction

endpackage

// File: rtl/oled_ser_tx.sv
module oled_ser_tx #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  input  logic       cmd_i,
  output logic       sclk_o,
  output logic       sdin_o,
  output logic       dc_o,
  output logic       done_o
);
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

  logic          act_q, hi_q;
  logic [2:0]    bit_q;
  logic [DW-1:0] div_q;
  logic [7:0]    sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_o <= 1'b1;
      dc_o   <= 1'b1;
      sdin_o <= 1'b0;
      done_o <= 1'b0;
      act_q  <= 1'b0;
      hi_q   <= 1'b0;
      bit_q  <= '0;
      div_q  <= '0;
      sh_q   <= '0;
    end else begin
      done_o <= 1'b0;
      if (!act_q) begin
        if (start_i) begin
          act_q  <= 1'b1;
          sh_q   <= byte_i;
          sdin_o <= byte_i[7];
          dc_o   <= ~cmd_i;
          sclk_o <= 1'b0;
          bit_q  <= '0;
          hi_q   <= 1'b0;
          div_q  <= '0;
        end
      end else if (div_q == DIV_LAST) begin
        div_q <= '0;
        if (!hi_q) begin
          sclk_o <= 1'b1;
          hi_q   <= 1'b1;
        end else if (bit_q == 3'd7) begin
          act_q  <= 1'b0;
          done_o <= 1'b1;
          dc_o   <= 1'b1;
        end else begin
          // data moves together with the falling edge only
          bit_q  <= bit_q + 3'd1;
          hi_q   <= 1'b0;
          sclk_o <= 1'b0;
          sdin_o <= sh_q[6];
          sh_q   <= {sh_q[6:0], 1'b0};
        end
      end else begin
        div_q <= div_q + DW'(1);
      end
    end
  end

endmodule

// File: rtl/oled_settle_timer.sv
module oled_settle_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == CW'(CYCLES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (en_i && !done_o)   cnt_q <= cnt_q + CW'(1);
  end

endmodule

// File: rtl/oled_seq_ctrl.sv
module oled_seq_ctrl
  import oled_seq_pkg::*;
#(
  parameter int PAGES = 8,
  parameter int COLS  = 128,
  parameter int AW    = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          refresh_i,
  input  logic          settle_done_i,
  input  logic          tx_done_i,
  input  logic [7:0]    fb_data_i,
  output logic          pwr_en_o,
  output logic          tx_start_o,
  output logic [7:0]    tx_byte_o,
  output logic          tx_cmd_o,
  output logic          fb_rd_o,
  output logic [AW-1:0] fb_addr_o,
  output logic          busy_o
);
  localparam int PW = $clog2(PAGES);
  localparam int IW = $clog2(COLS + HDR_LEN);
  localparam logic [IW-1:0] ITEM_LAST = IW'(COLS + HDR_LEN - 1);
  localparam logic [PW-1:0] PAGE_LAST = PW'(PAGES - 1);
  localparam logic [4:0]    IDX_LAST  = 5'(INIT_LEN - 1);

  seq_state_e    state_q;
  logic [4:0]    idx_q;
  logic [PW-1:0] page_q;
  logic [IW-1:0] item_q;
  logic          frame_q, pend_q;
  logic          is_data;

  assign is_data  = frame_q && (item_q >= IW'(HDR_LEN));
  assign busy_o   = (state_q != ST_IDLE);
  assign fb_addr_o = AW'(page_q) * AW'(COLS) + AW'(item_q) - AW'(HDR_LEN);

  always_comb begin
    tx_start_o = 1'b0;
    tx_byte_o  = 8'h00;
    tx_cmd_o   = 1'b0;
    fb_rd_o    = 1'b0;
    case (state_q)
      ST_ISSUE: begin
        if (!frame_q) begin
          tx_start_o = 1'b1;
          tx_cmd_o   = 1'b1;
          tx_byte_o  = init_byte(idx_q);
        end else if (!is_data) begin
          tx_start_o = 1'b1;
          tx_cmd_o   = 1'b1;
          case (item_q)
            IW'(0):  tx_byte_o = CMD_PAGE | 8'(page_q);
            IW'(1):  tx_byte_o = CMD_COL_LO;
            default: tx_byte_o = CMD_COL_HI;
          endcase
        end else begin
          fb_rd_o = 1'b1;
        end
      end
      ST_LOAD: begin
        tx_start_o = 1'b1;
        tx_byte_o  = fb_data_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_PWR;
      pwr_en_o <= 1'b0;
      idx_q    <= '0;
      page_q   <= '0;
      item_q   <= '0;
      frame_q  <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (state_q == ST_IDLE) pend_q <= 1'b0;
      else if (refresh_i)     pend_q <= 1'b1;
      case (state_q)
        ST_PWR: begin
          pwr_en_o <= 1'b1;
          state_q  <= ST_SETTLE;
        end
        ST_SETTLE: if (settle_done_i) state_q <= ST_ISSUE;
        ST_ISSUE:  state_q <= is_data ? ST_LOAD : ST_WAIT;
        ST_LOAD:   state_q <= ST_WAIT;
        ST_WAIT: if (tx_done_i) begin
          state_q <= ST_ISSUE;
          if (!frame_q) begin
            if (idx_q == IDX_LAST) state_q <= ST_IDLE;
            else                   idx_q   <= idx_q + 5'd1;
          end else if (item_q == ITEM_LAST) begin
            item_q <= '0;
            if (page_q == PAGE_LAST) state_q <= ST_IDLE;
            else                     page_q  <= page_q + PW'(1);
          end else begin
            item_q <= item_q + IW'(1);
          end
        end
        ST_IDLE: if (pend_q || refresh_i) begin
          frame_q <= 1'b1;
          page_q  <= '0;
          item_q  <= '0;
          state_q <= ST_ISSUE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/oled_refresh_seq.sv
module oled_refresh_seq #(
  parameter int SETTLE_CYC = 48000,
  parameter int CLK_DIV    = 4,
  parameter int PAGES      = 8,
  parameter int COLS       = 128,
  parameter int AW         = $clog2(PAGES * COLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          refresh_i,
  output logic          fb_rd_o,
  output logic [AW-1:0] fb_addr_o,
  input  logic [7:0]    fb_data_i,
  output logic          pwr_en_o,
  output logic          sclk_o,
  output logic          sdin_o,
  output logic          dc_o,
  output logic          busy_o
);
  logic       settle_done, tx_done, tx_start, tx_cmd;
  logic [7:0] tx_byte;

  oled_settle_timer #(.CYCLES(SETTLE_CYC)) i_settle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (pwr_en_o),
    .done_o (settle_done)
  );

  oled_seq_ctrl #(.PAGES(PAGES), .COLS(COLS), .AW(AW)) i_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .refresh_i     (refresh_i),
    .settle_done_i (settle_done),
    .tx_done_i     (tx_done),
    .fb_data_i     (fb_data_i),
    .pwr_en_o      (pwr_en_o),
    .tx_start_o    (tx_start),
    .tx_byte_o     (tx_byte),
    .tx_cmd_o      (tx_cmd),
    .fb_rd_o       (fb_rd_o),
    .fb_addr_o     (fb_addr_o),
    .busy_o        (busy_o)
  );

  oled_ser_tx #(.CLK_DIV(CLK_DIV)) i_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tx_start),
    .byte_i  (tx_byte),
    .cmd_i   (tx_cmd),
    .sclk_o  (sclk_o),
    .sdin_o  (sdin_o),
    .dc_o    (dc_o),
    .done_o  (tx_done)
  );

endmodule

// File: rtl/oled_seq_chk.sv
module oled_seq_chk #(
  parameter int AW       = 10,
  parameter int FB_DEPTH = 1024
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fb_rd_o,
  input logic [AW-1:0] fb_addr_o,
  input logic          pwr_en_o,
  input logic          sclk_o,
  input logic          sdin_o,
  input logic          dc_o,
  input logic          busy_o
);
  AST_IDLE_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (sclk_o && dc_o)); // R1
  AST_PWR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pwr_en_o) |-> pwr_en_o); // R2
  AST_NO_EDGE_UNPOWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o |-> (sclk_o && dc_o)); // R2
  AST_SDIN_LOW_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdin_o) |-> !sclk_o); // R4
  AST_DC_STEADY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(dc_o)); // R5
  AST_RD_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_rd_o |-> (32'(fb_addr_o) < FB_DEPTH)); // R7
  AST_RD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_rd_o |-> busy_o); // R9
endmodule

bind oled_refresh_seq oled_seq_chk #(.AW(AW), .FB_DEPTH(PAGES * COLS)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fb_rd_o   (fb_rd_o),
  .fb_addr_o (fb_addr_o),
  .pwr_en_o  (pwr_en_o),
  .sclk_o    (sclk_o),
  .sdin_o    (sdin_o),
  .dc_o      (dc_o),
  .busy_o    (busy_o)
);

// File: tb/test_oled_refresh_seq.sv
`timescale 1ns/1ps
module test_oled_refresh_seq;
  localparam int SETTLE  = 40;
  localparam int DIV     = 1;
  localparam int NINIT   = 24;
  localparam int FRAME_B = 8 * 131;
  localparam int TOTAL   = NINIT + 3 * FRAME_B;

  logic clk = 1'b0, rst_ni = 1'b0, refresh = 1'b0;
  logic fb_rd, pwr_en, sclk, sdin, dc, busy;
  logic [9:0] fb_addr;
  logic [7:0] fb_data = 8'h00;
  logic [7:0] mem [1024];

  int checks = 0, errors = 0, cyc = 0;
  int cyc_pwr = -1, cyc_first = -1, edges_unpowered = 0;
  int rx_n = 0, rx_bits = 0, mixed_dc = 0;
  logic [7:0] rx_sh = 8'h00;
  logic       rx_dc0 = 1'b1;
  logic [7:0] rx_byte [4096];
  logic       rx_dc   [4096];

  always #2.5 clk = ~clk;

  oled_refresh_seq #(.SETTLE_CYC(SETTLE), .CLK_DIV(DIV)) i_oled_refresh_seq (
    .clk_i(clk), .rst_ni(rst_ni), .refresh_i(refresh),
    .fb_rd_o(fb_rd), .fb_addr_o(fb_addr), .fb_data_i(fb_data),
    .pwr_en_o(pwr_en), .sclk_o(sclk), .sdin_o(sdin), .dc_o(dc), .busy_o(busy)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fb_rd) fb_data <= mem[fb_addr];
  end

  always @(posedge pwr_en) if (rst_ni && cyc_pwr < 0) cyc_pwr = cyc;

  always @(negedge sclk) if (rst_ni) begin
    if (!pwr_en) edges_unpowered++;
    if (cyc_first < 0) cyc_first = cyc;
  end

  always @(posedge sclk) if (rst_ni) begin
    rx_sh = {rx_sh[6:0], sdin};
    if (rx_bits == 0) rx_dc0 = dc;
    else if (dc != rx_dc0) mixed_dc++;
    rx_bits++;
    if (rx_bits == 8) begin
      if (rx_n < 4096) begin
        rx_byte[rx_n] = rx_sh;
        rx_dc[rx_n]   = rx_dc0;
      end
      rx_n++;
      rx_bits = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int sel, input int a);
    if (sel == 0) return 8'((a * 37 + (a >> 7)) & 255);
    return 8'((a & 255) ^ 8'hA5 ^ ((a >> 7) << 5));
  endfunction

  task automatic fill(input int sel);
    for (int a = 0; a < 1024; a++) mem[a] = pat(sel, a);
  endtask

  function automatic logic [7:0] init_exp(input int i);
    logic [7:0] t [24] = '{8'hAE, 8'hD5, 8'h80, 8'hA8, 8'h3F, 8'hD3, 8'h00, 8'h40,
                           8'hA1, 8'hC8, 8'hDA, 8'h12, 8'h81, 8'hFF, 8'h8D, 8'h14,
                           8'hD9, 8'hF1, 8'hDB, 8'h40, 8'hA4, 8'hA6, 8'h2E, 8'hAF};
    return t[i];
  endfunction

  task automatic pulse();
    @(negedge clk) refresh = 1'b1;
    @(negedge clk) refresh = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    while (cyc < 190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    summary();
  end

  initial begin
    fill(0);
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!pwr_en && sclk && dc && busy && !fb_rd, "R1 reset",
          {pwr_en, sclk, dc, busy, fb_rd}, 5'b01110);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(pwr_en === 1'b1, "R2 pwr_en after reset", pwr_en, 1);
    repeat (3) @(negedge clk);
    pulse(); // R8 request during settling
    wait (rx_n >= 300);
    @(negedge clk);
    check(busy === 1'b1, "R9 busy in frame", busy, 1);
    pulse(); // R8 two requests inside a frame collapse
    repeat (50) @(negedge clk);
    pulse();
    wait (rx_n >= NINIT + 2 * FRAME_B);
    wait (!busy);
    repeat (300) @(negedge clk);
    check(rx_n == NINIT + 2 * FRAME_B, "R8 R10 frame count", rx_n, NINIT + 2 * FRAME_B);
    check(!busy && sclk && dc, "R1 R9 idle levels", {busy, sclk, dc}, 3'b011);
    check(rx_bits == 0, "R4 no partial byte", rx_bits, 0);
    fill(1);
    pulse();
    @(negedge clk);
    check(busy === 1'b1, "R9 busy after idle request", busy, 1);
    wait (!busy);
    repeat (200) @(negedge clk);
    check(rx_n == TOTAL, "R10 total bytes", rx_n, TOTAL);
    check(rx_bits == 0, "R4 byte alignment", rx_bits, 0);
    check(mixed_dc == 0, "R5 dc steady within byte", mixed_dc, 0);
    check(edges_unpowered == 0, "R2 no edge before power", edges_unpowered, 0);
    check(cyc_pwr >= 0 && cyc_first - cyc_pwr >= SETTLE, "R2 settle delay",
          cyc_first - cyc_pwr, SETTLE);
    for (int k = 0; k < TOTAL && k < rx_n; k++) begin
      logic [7:0] eb;
      logic       ed;
      if (k < NINIT) begin
        eb = init_exp(k); ed = 1'b0; // R3
      end else begin
        int j, f, r, p, it;
        j = k - NINIT; f = j / FRAME_B; r = j % FRAME_B; p = r / 131; it = r % 131;
        if (it == 0)      begin eb = 8'hB0 | 8'(p); ed = 1'b0; end // R6
        else if (it == 1) begin eb = 8'h00; ed = 1'b0; end
        else if (it == 2) begin eb = 8'h10; ed = 1'b0; end
        else begin eb = pat(f < 2 ? 0 : 1, p * 128 + it - 3); ed = 1'b1; end // R7
      end
      check(rx_byte[k] == eb && rx_dc[k] == ed, k < NINIT ? "R3 R5 init byte" : "R6 R7 R4 frame byte",
            {rx_dc[k], rx_byte[k]}, {ed, eb});
    end
    summary();
  end
endmodule